// File: doc/BRIEF.md
# Privilege-Banked Stack Pointer Unit

This unit keeps the two mode bits that govern stacking in a processor core: a supervisor flag (S) and a master/interrupt select (M). It also holds three physical stack pointers, one for user code, one for interrupt handling and one for master (per-task) supervisor work. Every reference to the architectural stack register is steered to one of these pointers according to the current mode. The unit can read the chosen pointer, write it, pre-decrement it or post-increment it, by 2 or 4 bytes.

For each bus cycle the unit produces a 3-bit function code that tells the memory system whether the access is a user or supervisor access, and whether it is program or data. Requests that only supervisor code may make raise a one-cycle privilege-violation pulse when they arrive in user mode. Such requests are status-bit writes, explicit loads of a named pointer and instructions marked privileged, and the pulse leaves all state untouched. Exception entry forces supervisor mode in the same cycle, so a push made in that cycle lands on the supervisor stack.

Top module: `stack_bank_unit`

## Requirements
- R1: After reset S=1, M=0, all three pointers are zero and priv_viol is low.
- R2: The active pointer is the user pointer when S=0, the interrupt pointer when S=1 and M=0, and the master pointer when S=1 and M=1. Bank identifiers are 0 for user, 1 for interrupt and 2 for master.
- R3: sp_op 00 does nothing. 01 loads sp_wdata into the active pointer. 10 drives sp_addr with the active pointer minus the step and stores that value. 11 drives sp_addr with the active pointer and stores it plus the step. The step is 2 when sp_size=0 and 4 when sp_size=1. With any code other than 10, sp_addr shows the active pointer.
- R4: fc is 111 when cpu_space is high. Otherwise fc is 001 for user data, 010 for user program, 101 for supervisor data and 110 for supervisor program, with supervisor meaning S=1 or exc_entry high.
- R5: In supervisor mode, sr_wr loads sr_s and sr_m into S and M at the next clock edge.
- R6: With S=0 and exc_entry low, a request by sr_wr, priv_op or bank_wr makes priv_viol high in the following cycle only and changes neither S, M nor any pointer. In supervisor mode these requests raise no pulse.
- R7: exc_entry sets S to 1 and keeps M. A stack operation in the same cycle uses the supervisor pointer that M selects, and an sr_wr in that cycle is ignored.
- R8: bank_wr in supervisor mode loads sp_wdata into the pointer named by bank_id and leaves the other two unchanged. bank_id 3 changes nothing.
- R9: A stack operation issued together with sr_wr uses the mode from before the write. When bank_wr and sp_op target the same pointer in one cycle, the bank write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_op | input | 2 | Stack operation on the active pointer |
| sp_size | input | 1 | Step size: 0 = 2 bytes, 1 = 4 bytes |
| sp_wdata | input | AW | Data for pointer loads |
| bank_wr | input | 1 | Load the pointer named by bank_id (supervisor only) |
| bank_id | input | 2 | Target pointer of bank_wr |
| sr_wr | input | 1 | Write S and M (supervisor only) |
| sr_s | input | 1 | New S value |
| sr_m | input | 1 | New M value |
| priv_op | input | 1 | Privileged instruction requested |
| exc_entry | input | 1 | Exception entry, forces supervisor mode |
| is_prog | input | 1 | Current bus cycle is a program fetch |
| cpu_space | input | 1 | Current bus cycle is a CPU-space cycle |
| sp_addr | output | AW | Address produced by the stack reference |
| fc | output | 3 | Bus-cycle function code |
| s_flag | output | 1 | Current S bit |
| m_flag | output | 1 | Current M bit |
| priv_viol | output | 1 | One-cycle privilege-violation pulse |

## Verification
The unit has two pairs of functions that can fall in the same cycle. The first pair is exception entry and a pre-decrement push. The bench drives both from user mode with M set and then with M clear. It judges the result from sp_addr during that cycle, which must come from the master or the interrupt pointer, and from the stored value seen afterwards. The second pair puts a status write and a post-increment in one cycle, and a bank load and a stack step on the same pointer in another. The bench reads back every pointer after mode switches, which shows which operation won and that no other pointer moved.

// File: rtl/stack_bank_unit.sv
module stack_bank_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sp_op,
  input  logic          sp_size,
  input  logic [AW-1:0] sp_wdata,
  input  logic          bank_wr,
  input  logic [1:0]    bank_id,
  input  logic          sr_wr,
  input  logic          sr_s,
  input  logic          sr_m,
  input  logic          priv_op,
  input  logic          exc_entry,
  input  logic          is_prog,
  input  logic          cpu_space,
  output logic [AW-1:0] sp_addr,
  output logic [2:0]    fc,
  output logic          s_flag,
  output logic          m_flag,
  output logic          priv_viol
);
  localparam int NB = 3;
  localparam logic [1:0] OP_WR = 2'b01, OP_DEC = 2'b10, OP_INC = 2'b11;

  logic s_q, m_q;
  logic [AW-1:0] ptr_q [NB];
  logic s_eff, viol_req;
  logic [1:0] act;
  logic [AW-1:0] cur, step, dec, inc;
  logic [NB-1:0] wen_op, wen_bank;

  assign s_eff    = s_q | exc_entry;
  assign act      = !s_eff ? 2'd0 : (m_q ? 2'd2 : 2'd1);
  assign cur      = ptr_q[act];
  assign step     = sp_size ? AW'(4) : AW'(2);
  assign dec      = cur - step;
  assign inc      = cur + step;
  assign sp_addr  = (sp_op == OP_DEC) ? dec : cur;
  assign viol_req = !s_q && !exc_entry && (sr_wr || priv_op || bank_wr);
  assign fc       = cpu_space ? 3'b111 : {s_eff, is_prog, !is_prog};
  assign s_flag   = s_q;
  assign m_flag   = m_q;

  for (genvar i = 0; i < NB; i++) begin : g_wen
    assign wen_op[i]   = (sp_op != 2'b00) && (act == 2'(i));
    assign wen_bank[i] = bank_wr && s_eff && (bank_id == 2'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q       <= 1'b1;
      m_q       <= 1'b0;
      priv_viol <= 1'b0;
      for (int i = 0; i < NB; i++) ptr_q[i] <= '0;
    end else begin
      priv_viol <= viol_req;
      if (exc_entry) s_q <= 1'b1;
      else if (sr_wr && s_q) begin
        s_q <= sr_s;
        m_q <= sr_m;
      end
      for (int i = 0; i < NB; i++) begin
        if (wen_bank[i]) ptr_q[i] <= sp_wdata;
        else if (wen_op[i])
          case (sp_op)
            OP_WR:   ptr_q[i] <= sp_wdata;
            OP_DEC:  ptr_q[i] <= dec;
            OP_INC:  ptr_q[i] <= inc;
            default: ptr_q[i] <= ptr_q[i];
          endcase
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (s_q && !m_q && !priv_viol));
  assert_fc_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_q && !exc_entry && !cpu_space) |-> (fc[2] == 1'b0));
  assert_sr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && s_q && !exc_entry) |=> (s_q == $past(sr_s) && m_q == $past(sr_m)));
  assert_viol_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_req |=> priv_viol);
  assert_viol_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_req |=> (!s_q && m_q == $past(m_q)));
  assert_exc_super_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (s_q && m_q == $past(m_q)));
  assert_bank_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen_bank));
endmodule

// File: tb/stack_bank_unit_test.sv
module stack_bank_unit_test;
  localparam int AW = 32;

  typedef struct packed {
    logic        sr_wr, ns, nm, exc;
    logic [1:0]  op;
    logic        sz;
    logic [15:0] wd;
    logic        bw;
    logic [1:0]  bid;
    logic        pop, prog, cpu;
    logic [15:0] e_addr;
    logic [2:0]  e_fc;
    logic        e_s, e_m, e_viol;
    logic [15:0] e_ptr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h1000,1'b1,2'd0,1'b0,1'b0,1'b0,16'h0000,3'b101,1'b1,1'b0,1'b0,16'h0000},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h2000,1'b1,2'd1,1'b0,1'b0,1'b0,16'h0000,3'b101,1'b1,1'b0,1'b0,16'h2000},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h3000,1'b1,2'd2,1'b0,1'b1,1'b0,16'h2000,3'b110,1'b1,1'b0,1'b0,16'h2000},
    '{1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2000,3'b101,1'b1,1'b1,1'b0,16'h3000},
    '{1'b0,1'b0,1'b0,1'b0,2'd2,1'b1,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2FFC,3'b101,1'b1,1'b1,1'b0,16'h2FFC},
    '{1'b0,1'b0,1'b0,1'b0,2'd3,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2FFC,3'b101,1'b1,1'b1,1'b0,16'h2FFE},
    '{1'b0,1'b0,1'b0,1'b0,2'd1,1'b0,16'h3100,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2FFE,3'b101,1'b1,1'b1,1'b0,16'h3100},
    '{1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h3100,3'b101,1'b0,1'b1,1'b0,16'h1000},
    '{1'b0,1'b0,1'b0,1'b0,2'd3,1'b1,16'h0000,1'b0,2'd0,1'b0,1'b1,1'b0,16'h1000,3'b010,1'b0,1'b1,1'b0,16'h1004},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b1,16'h1004,3'b111,1'b0,1'b1,1'b0,16'h1004},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b1,1'b0,1'b0,16'h1004,3'b001,1'b0,1'b1,1'b1,16'h1004},
    '{1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h1004,3'b001,1'b0,1'b1,1'b1,16'h1004},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'hDEAD,1'b1,2'd1,1'b0,1'b0,1'b0,16'h1004,3'b001,1'b0,1'b1,1'b1,16'h1004},
    '{1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h30FC,3'b101,1'b1,1'b1,1'b0,16'h30FC},
    '{1'b1,1'b1,1'b0,1'b0,2'd3,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h30FC,3'b101,1'b1,1'b0,1'b0,16'h2000},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2000,3'b101,1'b0,1'b0,1'b0,16'h1004},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h1FFE,3'b101,1'b1,1'b0,1'b0,16'h1FFE},
    '{1'b0,1'b0,1'b0,1'b0,2'd3,1'b1,16'h2400,1'b1,2'd1,1'b0,1'b0,1'b0,16'h1FFE,3'b101,1'b1,1'b0,1'b0,16'h2400},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h5555,1'b1,2'd3,1'b0,1'b0,1'b0,16'h2400,3'b101,1'b1,1'b0,1'b0,16'h2400},
    '{1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h2400,3'b101,1'b1,1'b1,1'b0,16'h30FE},
    '{1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h30FE,3'b101,1'b0,1'b1,1'b0,16'h1004},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h1004,3'b001,1'b0,1'b1,1'b0,16'h1004},
    '{1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h1004,3'b001,1'b0,1'b1,1'b1,16'h1004},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,16'h1004,3'b001,1'b0,1'b1,1'b0,16'h1004}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sp_op = '0, bank_id = '0;
  logic sp_size = 0, bank_wr = 0, sr_wr = 0, sr_s = 0, sr_m = 0;
  logic priv_op = 0, exc_entry = 0, is_prog = 0, cpu_space = 0;
  logic [AW-1:0] sp_wdata = '0;
  logic [AW-1:0] sp_addr;
  logic [2:0] fc;
  logic s_flag, m_flag, priv_viol;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stack_bank_unit #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sp_op(sp_op), .sp_size(sp_size), .sp_wdata(sp_wdata),
    .bank_wr(bank_wr), .bank_id(bank_id), .sr_wr(sr_wr), .sr_s(sr_s), .sr_m(sr_m),
    .priv_op(priv_op), .exc_entry(exc_entry), .is_prog(is_prog), .cpu_space(cpu_space),
    .sp_addr(sp_addr), .fc(fc), .s_flag(s_flag), .m_flag(m_flag), .priv_viol(priv_viol)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sp_op = '0; sp_size = 0; sp_wdata = '0; bank_wr = 0; bank_id = '0;
    sr_wr = 0; sr_s = 0; sr_m = 0; priv_op = 0; exc_entry = 0; is_prog = 0; cpu_space = 0;
  endtask

  task automatic set_mode(input logic s, input logic m);
    @(negedge clk);
    sr_wr = 1; sr_s = s; sr_m = m;
    @(posedge clk); #1 idle();
  endtask

  initial begin
    idle();
    #22 rst_n = 1'b1;
    #1;
    chk("R1 s", AW'(s_flag), AW'(1));
    chk("R1 m", AW'(m_flag), AW'(0));
    chk("R1 viol", AW'(priv_viol), AW'(0));
    chk("R1 ptr", sp_addr, '0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sr_wr = VEC[i].sr_wr; sr_s = VEC[i].ns; sr_m = VEC[i].nm; exc_entry = VEC[i].exc;
      sp_op = VEC[i].op; sp_size = VEC[i].sz; sp_wdata = AW'(VEC[i].wd);
      bank_wr = VEC[i].bw; bank_id = VEC[i].bid; priv_op = VEC[i].pop;
      is_prog = VEC[i].prog; cpu_space = VEC[i].cpu;
      #2;
      chk($sformatf("R3 R7 addr v%0d", i), sp_addr, AW'(VEC[i].e_addr));
      chk($sformatf("R4 fc v%0d", i), AW'(fc), AW'(VEC[i].e_fc));
      @(posedge clk); #1 idle(); #1;
      chk($sformatf("R5 R7 s v%0d", i), AW'(s_flag), AW'(VEC[i].e_s));
      chk($sformatf("R5 R7 m v%0d", i), AW'(m_flag), AW'(VEC[i].e_m));
      chk($sformatf("R6 viol v%0d", i), AW'(priv_viol), AW'(VEC[i].e_viol));
      chk($sformatf("R2 R8 R9 ptr v%0d", i), sp_addr, AW'(VEC[i].e_ptr));
    end
    @(negedge clk); rst_n = 1'b0;
    #3; rst_n = 1'b1; #1;
    chk("R1 s again", AW'(s_flag), AW'(1));
    chk("R1 m again", AW'(m_flag), AW'(0));
    chk("R1 isp cleared", sp_addr, '0);
    set_mode(1'b1, 1'b1); #1;
    chk("R1 msp cleared", sp_addr, '0);
    set_mode(1'b0, 1'b0); #1;
    chk("R1 usp cleared", sp_addr, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule